// File: doc/BRIEF.md
# Second-Operand Shifter with Carry-Out

This combinational block forms the second source operand of a 32-bit integer datapath and the carry produced by the shifter. It reads the instruction word, the value of the register to be shifted, the low byte of the register that can supply a shift amount, and the current carry flag. It returns the shaped operand and the shifter carry. The result is ready in the same cycle as the inputs. There is no register stage and no handshake, so the surrounding pipeline decides when to sample it.

The block has two forms. In the immediate form, an 8-bit constant is rotated right by an even amount. In the register form, the register value is shifted by a 5-bit constant or by a register-held byte. Four shift kinds are supported: logical left, logical right, arithmetic right and rotate right. A zero amount given as a constant has a special meaning for three of the kinds, including a one-bit rotate through the carry. Register-held amounts of 32 and above follow their own rules for the result and the carry.

Top module: `opnd_shifter`

## Requirements
- R1: When instruction bit 25 is 1 (immediate form), the operand is the zero-extended byte in bits 7:0, rotated right by twice the unsigned value in bits 11:8.
- R2: In the immediate form, if the rotate count is zero the carry-out equals the carry input; otherwise it equals bit 31 of the operand.
- R3: When bit 25 is 0 (register form), bits 6:5 choose the kind (00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right). Bit 4 = 1 takes the amount from the Rs low byte, and bit 4 = 0 takes it from bits 11:7. For amounts 1 to 31 the operand is the Rm value shifted or rotated, and the carry-out is the last bit moved out of it.
- R4: A constant logical-left amount of 0 gives the Rm value unchanged and passes the carry input through.
- R5: A constant logical-right amount of 0 acts as a shift by 32: the operand is 0 and the carry-out is Rm bit 31.
- R6: A constant arithmetic-right amount of 0 acts as a shift by 32: every operand bit and the carry-out equal Rm bit 31.
- R7: A constant rotate amount of 0 rotates one place through the carry: the operand is {carry input, Rm[31:1]} and the carry-out is Rm bit 0.
- R8: A register-held amount of 0 gives the Rm value unchanged and passes the carry input through, whatever the kind.
- R9: Register-held logical shifts of 32 or more give an operand of 0. At exactly 32 the carry-out is Rm bit 0 for a left shift and Rm bit 31 for a right shift. Above 32 the carry-out is 0.
- R10: A register-held arithmetic-right amount of 32 or more fills the operand with Rm bit 31, and the carry-out is Rm bit 31.
- R11: For a register-held rotate with a nonzero amount whose low 5 bits are zero, the operand is Rm unchanged and the carry-out is Rm bit 31. Any other nonzero amount rotates by its low 5 bits.
- R12: Instruction bits 31:26 and 24:12 have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_word | input | 32 | Instruction word holding the form, kind and amount fields |
| rm_val | input | 32 | Value of the register to be shifted |
| rs_low | input | 8 | Low byte of the register supplying a shift amount |
| carry_in | input | 1 | Current carry flag |
| operand_out | output | 32 | Shaped second operand |
| carry_out | output | 1 | Shifter carry-out |

## Verification
The bench sweeps every register-held amount from 0 to 255 for every kind. This covers the boundary at 32 and the cases above it. A design that failed to clamp there would wrap the amount modulo 32 and return a shifted value instead of 0 or a sign fill. A design that handled the exact-32 case wrongly would return the wrong carry bit. The bench also covers each constant zero-amount encoding. A design that missed the rotate-through-carry case would return Rm unchanged, and one that missed the logical-right case would keep Rm instead of returning 0. The immediate-form sweep checks that a zero rotation keeps the incoming carry instead of copying bit 31, and the unused-bit test checks that stray instruction bits do not change the result.

// File: rtl/sho_pkg.sv
package sho_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned SHAMT_W = $clog2(WORD_W);
  localparam int unsigned RSBYTE_W = 8;
  localparam int unsigned IMM_W = 8;
  localparam int unsigned ROTF_W = 4;

  typedef enum logic [1:0] {
    SK_LSL = 2'b00,
    SK_LSR = 2'b01,
    SK_ASR = 2'b10,
    SK_ROR = 2'b11
  } shift_kind_e;

  typedef struct packed {
    logic               is_zero;
    logic               at_width;
    logic               past_width;
    logic [SHAMT_W-1:0] low;
  } amt_info_t;
endpackage

// File: rtl/sho_imm_rot.sv
module sho_imm_rot
  import sho_pkg::*;
#(
  parameter int unsigned W    = WORD_W,
  parameter int unsigned IW   = IMM_W,
  parameter int unsigned RW   = ROTF_W,
  localparam int unsigned AW  = RW + 1
) (
  input  logic [IW-1:0] imm_byte,
  input  logic [RW-1:0] rot_half,
  input  logic          c_in,
  output logic [W-1:0]  rot_res,
  output logic          rot_c
);
  logic [AW-1:0]  rot_amt;
  logic [W-1:0]   base;
  logic [2*W-1:0] doubled;
  logic [2*W-1:0] moved;

  assign rot_amt = {rot_half, 1'b0};
  assign base    = {{(W-IW){1'b0}}, imm_byte};
  assign doubled = {base, base};
  assign moved   = doubled >> rot_amt;
  assign rot_res = moved[W-1:0];
  assign rot_c   = (rot_amt == '0) ? c_in : moved[W-1];
endmodule

// File: rtl/sho_amount_sel.sv
module sho_amount_sel
  import sho_pkg::*;
#(
  parameter int unsigned W    = WORD_W,
  parameter int unsigned BW   = RSBYTE_W,
  localparam int unsigned SW  = $clog2(W)
) (
  input  logic          by_reg,
  input  logic [SW-1:0] const_amt,
  input  logic [BW-1:0] reg_amt,
  output amt_info_t     info
);
  logic [BW-1:0] raw;

  assign raw             = by_reg ? reg_amt : {{(BW-SW){1'b0}}, const_amt};
  assign info.is_zero    = (raw == '0);
  assign info.at_width   = (raw == BW'(W));
  assign info.past_width = (raw > BW'(W));
  assign info.low        = raw[SW-1:0];
endmodule

// File: rtl/sho_barrel.sv
module sho_barrel
  import sho_pkg::*;
#(
  parameter int unsigned W    = WORD_W,
  localparam int unsigned SW  = $clog2(W)
) (
  input  logic [W-1:0]  src,
  input  shift_kind_e   kind,
  input  logic [SW-1:0] amt,
  output logic [W-1:0]  res,
  output logic          res_c
);
  logic [W:0]   lft [0:SW];
  logic [W:0]   rgt [0:SW];
  logic [W-1:0] rot [0:SW];
  logic         fill;

  assign fill   = (kind == SK_ASR) & src[W-1];
  assign lft[0] = {1'b0, src};
  assign rgt[0] = {src, 1'b0};
  assign rot[0] = src;

  for (genvar g = 0; g < SW; g++) begin : g_stage
    localparam int unsigned D = 1 << g;
    assign lft[g+1] = amt[g] ? {lft[g][W-D:0], {D{1'b0}}} : lft[g];
    assign rgt[g+1] = amt[g] ? {{D{fill}}, rgt[g][W:D]}   : rgt[g];
    assign rot[g+1] = amt[g] ? {rot[g][D-1:0], rot[g][W-1:D]} : rot[g];
  end

  always_comb begin
    unique case (kind)
      SK_LSL: begin
        res   = lft[SW][W-1:0];
        res_c = lft[SW][W];
      end
      SK_ROR: begin
        res   = rot[SW];
        res_c = rot[SW][W-1];
      end
      default: begin
        res   = rgt[SW][W:1];
        res_c = rgt[SW][0];
      end
    endcase
  end
endmodule

// File: rtl/opnd_shifter.sv
module opnd_shifter
  import sho_pkg::*;
#(
  parameter int unsigned W    = WORD_W,
  parameter int unsigned BW   = RSBYTE_W,
  localparam int unsigned SW  = $clog2(W)
) (
  input  logic [31:0]   instr_word,
  input  logic [W-1:0]  rm_val,
  input  logic [BW-1:0] rs_low,
  input  logic          carry_in,
  output logic [W-1:0]  operand_out,
  output logic          carry_out
);
  logic        imm_form;
  logic        by_reg;
  shift_kind_e kind;
  amt_info_t   info;
  logic [W-1:0] imm_res, bar_res, sign_fill;
  logic         imm_c, bar_c;

  assign imm_form  = instr_word[25];
  assign by_reg    = instr_word[4];
  assign kind      = shift_kind_e'(instr_word[6:5]);
  assign sign_fill = {W{rm_val[W-1]}};

  sho_imm_rot #(.W(W)) u_imm (
    .imm_byte (instr_word[7:0]),
    .rot_half (instr_word[11:8]),
    .c_in     (carry_in),
    .rot_res  (imm_res),
    .rot_c    (imm_c)
  );

  sho_amount_sel #(.W(W), .BW(BW)) u_amt (
    .by_reg    (by_reg),
    .const_amt (instr_word[7+SW-1:7]),
    .reg_amt   (rs_low),
    .info      (info)
  );

  sho_barrel #(.W(W)) u_bar (
    .src   (rm_val),
    .kind  (kind),
    .amt   (info.low),
    .res   (bar_res),
    .res_c (bar_c)
  );

  always_comb begin
    operand_out = bar_res;
    carry_out   = bar_c;
    if (imm_form) begin
      operand_out = imm_res;
      carry_out   = imm_c;
    end else if (info.is_zero) begin
      operand_out = rm_val;
      carry_out   = carry_in;
      if (!by_reg) begin
        unique case (kind)
          SK_LSR: begin operand_out = '0;        carry_out = rm_val[W-1]; end
          SK_ASR: begin operand_out = sign_fill; carry_out = rm_val[W-1]; end
          SK_ROR: begin operand_out = {carry_in, rm_val[W-1:1]}; carry_out = rm_val[0]; end
          default: ;
        endcase
      end
    end else if (info.at_width || info.past_width) begin
      unique case (kind)
        SK_LSL: begin operand_out = '0; carry_out = info.at_width & rm_val[0];   end
        SK_LSR: begin operand_out = '0; carry_out = info.at_width & rm_val[W-1]; end
        SK_ASR: begin operand_out = sign_fill; carry_out = rm_val[W-1]; end
        default: begin
          if (info.low == '0) begin
            operand_out = rm_val;
            carry_out   = rm_val[W-1];
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/sho_checker.sv
module sho_checker (
  input logic [31:0] instr_word,
  input logic [31:0] rm_val,
  input logic [7:0]  rs_low,
  input logic        carry_in,
  input logic [31:0] operand_out,
  input logic        carry_out
);
  logic known;
  logic regform, regamt;
  logic [1:0] kd;

  assign known   = !$isunknown({instr_word, rm_val, rs_low, carry_in, operand_out, carry_out});
  assign regform = !instr_word[25];
  assign regamt  = regform && instr_word[4];
  assign kd      = instr_word[6:5];

  always_comb begin
    if (known) begin
      // R1
      imm_popcount_chk: assert (!instr_word[25] ||
        $countones(operand_out) == $countones(instr_word[7:0]))
        else $error("immediate rotation changed bit count");
      // R2
      imm_norot_carry_chk: assert (!(instr_word[25] && instr_word[11:8] == 4'd0) ||
        (carry_out == carry_in && operand_out == {24'd0, instr_word[7:0]}))
        else $error("zero rotation altered operand or carry");
      // R5
      lsr_const_zero_chk: assert (!(regform && !instr_word[4] && kd == 2'b01 &&
        instr_word[11:7] == 5'd0) || (operand_out == 32'd0 && carry_out == rm_val[31]))
        else $error("constant right shift by zero not treated as 32");
      // R8
      reg_zero_amt_chk: assert (!(regamt && rs_low == 8'd0) ||
        (operand_out == rm_val && carry_out == carry_in))
        else $error("register amount zero not a passthrough");
      // R9
      wide_logical_chk: assert (!(regamt && !kd[1] && rs_low > 8'd32) ||
        (operand_out == 32'd0 && !carry_out))
        else $error("logical shift past width not cleared");
      // R10
      asr_wide_chk: assert (!(regamt && kd == 2'b10 && rs_low >= 8'd32) ||
        (operand_out == {32{rm_val[31]}} && carry_out == rm_val[31]))
        else $error("arithmetic shift past width not sign filled");
      // R11
      ror_mult_chk: assert (!(regamt && kd == 2'b11 && rs_low != 8'd0 && rs_low[4:0] == 5'd0) ||
        (operand_out == rm_val && carry_out == rm_val[31]))
        else $error("rotate by multiple of width wrong");
    end
  end
endmodule

bind opnd_shifter sho_checker u_sho_chk (
  .instr_word  (instr_word),
  .rm_val      (rm_val),
  .rs_low      (rs_low),
  .carry_in    (carry_in),
  .operand_out (operand_out),
  .carry_out   (carry_out)
);

// File: tb/tb_opnd_shifter.sv
module tb_opnd_shifter;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] ir, rm;
  logic [7:0]  rs;
  logic        cin;
  logic [31:0] operand_out;
  logic        carry_out;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  opnd_shifter dut (
    .instr_word  (ir),
    .rm_val      (rm),
    .rs_low      (rs),
    .carry_in    (cin),
    .operand_out (operand_out),
    .carry_out   (carry_out)
  );

  // Iterative model: one bit position per step, written from the requirements.
  function automatic logic [32:0] model(input logic [31:0] i, input logic [31:0] m,
                                        input logic [7:0] s, input logic ci);
    logic [31:0] op;
    logic c;
    int k;
    if (i[25]) begin
      k  = 2 * int'(i[11:8]);
      op = {24'd0, i[7:0]};
      for (int t = 0; t < k; t++) op = {op[0], op[31:1]};
      c = (k == 0) ? ci : op[31];
    end else begin
      k  = i[4] ? int'(s) : int'(i[11:7]);
      op = m;
      c  = ci;
      if (!i[4] && k == 0) begin
        case (i[6:5])
          2'b01: begin op = 32'd0; c = m[31]; end
          2'b10: begin op = {32{m[31]}}; c = m[31]; end
          2'b11: begin op = {ci, m[31:1]}; c = m[0]; end
          default: ;
        endcase
      end else begin
        for (int t = 0; t < k; t++) begin
          case (i[6:5])
            2'b00: begin c = op[31]; op = op << 1; end
            2'b01: begin c = op[0];  op = op >> 1; end
            2'b10: begin c = op[0];  op = {op[31], op[31:1]}; end
            default: begin c = op[0]; op = {op[0], op[31:1]}; end
          endcase
        end
      end
    end
    return {c, op};
  endfunction

  function automatic string req_of(input logic [31:0] i, input logic [7:0] s);
    int k;
    if (i[25]) return (i[11:8] == 0) ? "R2" : "R1";
    k = i[4] ? int'(s) : int'(i[11:7]);
    if (k == 0) begin
      if (i[4]) return "R8";
      case (i[6:5])
        2'b00: return "R4";
        2'b01: return "R5";
        2'b10: return "R6";
        default: return "R7";
      endcase
    end
    if (i[6:5] == 2'b11 && k >= 32) return "R11";
    if (k >= 32) return (i[6:5] == 2'b10) ? "R10" : "R9";
    return "R3";
  endfunction

  function automatic logic [31:0] mk_imm(input logic [3:0] rot, input logic [7:0] b);
    return 32'hE200_0000 | {20'd0, rot, b};
  endfunction

  function automatic logic [31:0] mk_cst(input logic [1:0] kd, input logic [4:0] a);
    return 32'hE000_0000 | {20'd0, a, kd, 1'b0, 4'h3};
  endfunction

  function automatic logic [31:0] mk_reg(input logic [1:0] kd);
    return 32'hE000_0000 | {20'd0, 4'h2, 1'b0, kd, 1'b1, 4'h3};
  endfunction

  task automatic apply_check(input logic [31:0] i, input logic [31:0] m, input logic [7:0] s,
                             input logic c, input logic [32:0] exp, input string tag);
    @(negedge clk);
    ir = i; rm = m; rs = s; cin = c;
    #2;
    n_chk++;
    if ({carry_out, operand_out} !== exp) begin
      n_bad++;
      $display("FAIL %s ir=%h rm=%h rs=%0d cin=%0b actual c=%0b op=%h expected c=%0b op=%h",
               tag, i, m, s, c, carry_out, operand_out, exp[32], exp[31:0]);
    end
  endtask

  task automatic chk(input logic [31:0] i, input logic [31:0] m, input logic [7:0] s, input logic c);
    apply_check(i, m, s, c, model(i, m, s, c), req_of(i, s));
  endtask

  task automatic t_reset_state;
    // R4: all-zero inputs are a constant left shift by 0 of zero
    apply_check(32'd0, 32'd0, 8'd0, 1'b0, 33'd0, "R4 reset");
  endtask

  task automatic t_imm_rotations;
    logic [7:0] bytes [4] = '{8'h81, 8'hFF, 8'h01, 8'h00};
    for (int r = 0; r < 16; r++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 2; c++)
          chk(mk_imm(4'(r), bytes[b]), 32'hDEAD_BEEF, 8'h5A, c[0]);
  endtask

  task automatic t_const_amounts;
    logic [31:0] vals [3] = '{32'h8000_0001, 32'h5A3C_96E1, 32'h7FFF_FFFE};
    for (int kd = 0; kd < 4; kd++)
      for (int a = 0; a < 32; a++)
        for (int v = 0; v < 3; v++)
          for (int c = 0; c < 2; c++)
            chk(mk_cst(2'(kd), 5'(a)), vals[v], 8'hFF, c[0]);
  endtask

  task automatic t_reg_amounts;
    logic [31:0] vals [2] = '{32'h8000_0001, 32'h3C5A_E169};
    for (int kd = 0; kd < 4; kd++)
      for (int a = 0; a < 256; a++)
        for (int v = 0; v < 2; v++)
          for (int c = 0; c < 2; c++)
            chk(mk_reg(2'(kd)), vals[v], 8'(a), c[0]);
  endtask

  task automatic t_unused_bits;
    logic [31:0] bases [4];
    logic [31:0] junk;
    bases[0] = mk_imm(4'd3, 8'hA5);
    bases[1] = mk_cst(2'b11, 5'd0);
    bases[2] = mk_reg(2'b10);
    bases[3] = mk_cst(2'b01, 5'd7);
    for (int b = 0; b < 4; b++) begin
      junk = (32'h9E5A_3000 ^ (32'h1357_9000 * b)) & 32'hFDFF_F000;
      // R12: stray bits must not move either output
      apply_check((bases[b] & ~32'hFDFF_F000) | junk, 32'hC001_0FF3, 8'd40, 1'b1,
                  model(bases[b], 32'hC001_0FF3, 8'd40, 1'b1), "R12");
    end
  endtask

  initial begin
    rst = 1'b1; ir = '0; rm = '0; rs = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    t_reset_state();
    rst = 1'b0;
    t_imm_rotations();
    t_const_amounts();
    t_reg_amounts();
    t_unused_bits();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R3 watchdog: actual run unfinished, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule